// File: doc/BRIEF.md
# Multi-Tap Swept Audio Delay Line

This block is an audio delay effect built around one single-port sample store used as a ring. Each incoming audio sample is written once into the ring. The block then reads a small number of delayed samples back from the same port, one after another, on a system clock that runs far faster than the audio rate. At 40 kHz one sample period is 25 µs, so a clock in the low megahertz range leaves room for many taps. A one-second delay at that rate needs a ring of roughly 40000 words. The ring depth is a parameter, and the address width follows from it.

Each tap has its own delay distance. That distance is not fixed: a per-tap triangle sweeper moves it up and down by a configured step once per sample period, between a configured floor and ceiling, which gives a chorus-like moving delay. Every tapped sample is halved with an arithmetic right shift. It is then added to or subtracted from the newest sample, which is kept in a register and never read back from the ring. The sum is clipped to the sample range. A one-clock strobe marks each finished result. A sample strobe that arrives while a sequence is still running is dropped and reported.

The sequencer has five states. IDLE waits for a strobe. WRITE stores the sample and seeds the sum. READ issues one ring read per active tap. DRAIN folds in the last read. EMIT drives the result, steps the write position and advances every sweeper. The transitions are:
- IDLE→WRITE on an accepted strobe.
- WRITE→READ when at least one tap is active, otherwise WRITE→DRAIN.
- READ→READ until the last active tap has been issued, then READ→DRAIN.
- DRAIN→EMIT, then EMIT→IDLE.

Top module: `tap_delay_engine`

## Requirements
- R1: While reset is held, and afterwards until the first result, out_valid and overrun are low and out_data is zero.
- R2: Each accepted strobe produces exactly one out_valid pulse, one clock wide. It appears N+3 rising edges after the edge that sampled the strobe, where N is the cfg_taps value latched at that edge.
- R3: With cfg_taps equal to zero, out_data equals the current sample.
- R4: out_data is the current sample plus, for each active tap i in index order 0..N-1, the tapped sample shifted right arithmetically by one (rounding toward minus infinity). The term is subtracted when cfg_sub bit i is 1 and added when it is 0.
- R5: The result is clipped to the signed range from -2^(SAMPLE_W-1) to 2^(SAMPLE_W-1)-1 instead of wrapping.
- R6: The write position starts at 0, steps by one per accepted sample and wraps at DEPTH. A tap with delay d reads the sample accepted d samples earlier, and a delay of 0 returns the current sample.
- R7: Each tap's delay starts at 0 and rising. After each result, a rising delay becomes delay+step, or becomes the ceiling and turns falling if delay+step reaches the ceiling. A falling delay becomes delay-step, or becomes the floor and turns rising if delay is at most floor+step. Step, floor and ceiling for tap i sit in bits [i*ADDR_W +: ADDR_W] of cfg_step, cfg_lo and cfg_hi.
- R8: A strobe seen while the sequencer is not in IDLE raises overrun for one clock on the next edge. That sample is dropped: it produces no result, no write, no pointer step and no sweeper step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | New-sample strobe |
| smp_in | input | SAMPLE_W | Signed input sample |
| cfg_taps | input | TAPW | Number of active taps (0..MAX_TAPS) |
| cfg_sub | input | MAX_TAPS | Per-tap sign: 1 subtracts, 0 adds |
| cfg_step | input | MAX_TAPS*ADDR_W | Per-tap sweep step |
| cfg_lo | input | MAX_TAPS*ADDR_W | Per-tap delay floor |
| cfg_hi | input | MAX_TAPS*ADDR_W | Per-tap delay ceiling (below DEPTH) |
| out_valid | output | 1 | One-clock result strobe |
| out_data | output | SAMPLE_W | Signed clipped result |
| overrun | output | 1 | One-clock pulse for a dropped strobe |

## Verification
A wrong write position or a wrong sweeper value does not show at once. It shows in the first result whose tap reaches a ring slot other than the expected one. Because the stimulus is a pseudo-random sample stream, that result differs from the arithmetic model in almost every case. A sequencer fault shows in the very next result as a changed strobe latency or a missing tap term. A dropped-sample fault that still steps the pointer or a sweeper shifts every later tap address and corrupts the outputs that follow.

// File: rtl/tde_pkg.sv
package tde_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DRAIN,
        ST_EMIT
    } tde_state_e;

endpackage

// File: rtl/tde_sample_ram.sv
module tde_sample_ram #(
    parameter int WIDTH  = 16,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    // single port: a cycle either writes or reads
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end else begin
            rdata <= store[addr];
        end
    end

endmodule

// File: rtl/tde_sweep_gen.sv
module tde_sweep_gen #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic [ADDR_W-1:0] ofs
);

    logic              rising_q;
    logic [ADDR_W:0]   up_sum;
    logic [ADDR_W:0]   floor_band;

    assign up_sum     = {1'b0, ofs} + {1'b0, step};
    assign floor_band = {1'b0, lo} + {1'b0, step};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs      <= '0;
            rising_q <= 1'b1;
        end else if (adv) begin
            if (rising_q) begin
                if (up_sum >= {1'b0, hi}) begin
                    ofs      <= hi;
                    rising_q <= 1'b0;
                end else begin
                    ofs <= up_sum[ADDR_W-1:0];
                end
            end else begin
                if ({1'b0, ofs} <= floor_band) begin
                    ofs      <= lo;
                    rising_q <= 1'b1;
                end else begin
                    ofs <= ofs - step;
                end
            end
        end
    end

endmodule

// File: rtl/tap_delay_engine.sv
module tap_delay_engine
    import tde_pkg::*;
#(
    parameter  int SAMPLE_W = 16,
    parameter  int DEPTH    = 64,
    parameter  int MAX_TAPS = 3,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int TAPW     = $clog2(MAX_TAPS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [SAMPLE_W-1:0]          smp_in,
    input  logic [TAPW-1:0]              cfg_taps,
    input  logic [MAX_TAPS-1:0]          cfg_sub,
    input  logic [MAX_TAPS*ADDR_W-1:0]   cfg_step,
    input  logic [MAX_TAPS*ADDR_W-1:0]   cfg_lo,
    input  logic [MAX_TAPS*ADDR_W-1:0]   cfg_hi,
    output logic                         out_valid,
    output logic [SAMPLE_W-1:0]          out_data,
    output logic                         overrun
);

    localparam int ACC_W = SAMPLE_W + TAPW + 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 <<< (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    tde_state_e state_q, state_d;

    logic [SAMPLE_W-1:0]      cur_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic [TAPW-1:0]          tap_q;
    logic [TAPW-1:0]          ntap_q;
    logic [ADDR_W-1:0]        wptr_q;
    logic                     rd_pend_q;
    logic                     rd_sub_q;
    logic                     busy;

    logic [ADDR_W-1:0]        ofs [MAX_TAPS];
    logic [MAX_TAPS*ADDR_W-1:0] ofs_flat;
    logic [ADDR_W-1:0]        sel_ofs;
    logic                     sel_sub;
    logic [ADDR_W:0]          diff;
    logic [ADDR_W-1:0]        raddr;
    logic [ADDR_W-1:0]        ram_addr;
    logic                     ram_we;
    logic [SAMPLE_W-1:0]      ram_rdata;
    logic signed [ACC_W-1:0]  rd_ext;
    logic signed [ACC_W-1:0]  rd_half;
    logic signed [ACC_W-1:0]  cur_ext;
    logic                     sweep_adv;

    assign busy      = (state_q != ST_IDLE);
    assign sweep_adv = (state_q == ST_EMIT);

    // per-tap delay sweepers
    for (genvar g = 0; g < MAX_TAPS; g++) begin : g_sweep
        tde_sweep_gen #(.ADDR_W(ADDR_W)) u_sweep (
            .clk  (clk),
            .rst_n(rst_n),
            .adv  (sweep_adv),
            .step (cfg_step[g*ADDR_W +: ADDR_W]),
            .lo   (cfg_lo[g*ADDR_W +: ADDR_W]),
            .hi   (cfg_hi[g*ADDR_W +: ADDR_W]),
            .ofs  (ofs[g])
        );
        assign ofs_flat[g*ADDR_W +: ADDR_W] = ofs[g];
    end

    // select the delay and sign of the tap being issued
    always_comb begin
        sel_ofs = ofs[0];
        sel_sub = cfg_sub[0];
        for (int i = 1; i < MAX_TAPS; i++) begin
            if (tap_q == TAPW'(i)) begin
                sel_ofs = ofs[i];
                sel_sub = cfg_sub[i];
            end
        end
    end

    // ring address of the tap: write position minus delay, modulo depth
    assign diff  = {1'b0, wptr_q} - {1'b0, sel_ofs};
    assign raddr = diff[ADDR_W] ? ADDR_W'(diff + (ADDR_W + 1)'(DEPTH))
                                : diff[ADDR_W-1:0];

    assign ram_we   = (state_q == ST_WRITE);
    assign ram_addr = ram_we ? wptr_q : raddr;

    tde_sample_ram #(
        .WIDTH (SAMPLE_W),
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (ram_addr),
        .wdata(cur_q),
        .rdata(ram_rdata)
    );

    assign rd_ext  = ACC_W'($signed(ram_rdata));
    assign rd_half = rd_ext >>> 1;
    assign cur_ext = ACC_W'($signed(cur_q));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (smp_valid) state_d = ST_WRITE;
            ST_WRITE: state_d = (ntap_q == '0) ? ST_DRAIN : ST_READ;
            ST_READ:  if (tap_q == ntap_q - TAPW'(1)) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            acc_q     <= '0;
            tap_q     <= '0;
            ntap_q    <= '0;
            wptr_q    <= '0;
            rd_pend_q <= 1'b0;
            rd_sub_q  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            overrun   <= smp_valid && busy;
            rd_pend_q <= (state_q == ST_READ);
            rd_sub_q  <= sel_sub;

            if (rd_pend_q) begin
                acc_q <= rd_sub_q ? (acc_q - rd_half) : (acc_q + rd_half);
            end

            unique case (state_q)
                ST_IDLE: begin
                    if (smp_valid) begin
                        cur_q  <= smp_in;
                        ntap_q <= (cfg_taps > TAPW'(MAX_TAPS)) ? TAPW'(MAX_TAPS) : cfg_taps;
                    end
                end
                ST_WRITE: begin
                    acc_q <= cur_ext;
                    tap_q <= '0;
                end
                ST_READ: begin
                    tap_q <= tap_q + TAPW'(1);
                end
                ST_DRAIN: begin
                end
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    if (acc_q > SAT_HI) begin
                        out_data <= SAT_HI[SAMPLE_W-1:0];
                    end else if (acc_q < SAT_LO) begin
                        out_data <= SAT_LO[SAMPLE_W-1:0];
                    end else begin
                        out_data <= acc_q[SAMPLE_W-1:0];
                    end
                    wptr_q <= (wptr_q == ADDR_W'(DEPTH - 1)) ? '0 : wptr_q + ADDR_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/tde_checker.sv
module tde_checker #(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 64,
    parameter int NOFS   = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              busy,
    input logic              out_valid,
    input logic              overrun,
    input logic [ADDR_W-1:0] wptr_q,
    input logic [NOFS-1:0]   ofs_flat
);

    // R2: the result strobe lasts a single clock
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: an overrun pulse only follows a strobe seen while busy
    a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(smp_valid) && $past(busy)));

    // R6: the write position moves only with a result, by one, wrapping
    a_r6_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wptr_q) |-> (out_valid &&
            (wptr_q == (($past(wptr_q) == ADDR_W'(DEPTH - 1)) ? '0 : $past(wptr_q) + ADDR_W'(1)))));

    // R7: sweepers move only when a result is produced
    a_r7_sweep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ofs_flat) |-> out_valid);

    // R1: outputs quiet right after reset release
    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !overrun));

endmodule

bind tap_delay_engine tde_checker #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH),
    .NOFS  (MAX_TAPS * ADDR_W)
) u_tde_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .busy     (busy),
    .out_valid(out_valid),
    .overrun  (overrun),
    .wptr_q   (wptr_q),
    .ofs_flat (ofs_flat)
);

// File: tb/tap_delay_engine_bench.sv
module tap_delay_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW   = 16;
    localparam int DEP  = 64;
    localparam int NT   = 3;
    localparam int AW   = 6;
    localparam int TW   = 2;
    localparam int HMAX = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [SW-1:0]     smp_in = '0;
    logic [TW-1:0]     cfg_taps = '0;
    logic [NT-1:0]     cfg_sub = '0;
    logic [NT*AW-1:0]  cfg_step = '0;
    logic [NT*AW-1:0]  cfg_lo = '0;
    logic [NT*AW-1:0]  cfg_hi = '0;
    logic              out_valid;
    logic [SW-1:0]     out_data;
    logic              overrun;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int hist [HMAX];
    int k = 0;
    int m_ofs [NT];
    int m_up  [NT];
    int stp [NT];
    int lo  [NT];
    int hi  [NT];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_delay_engine #(.SAMPLE_W(SW), .DEPTH(DEP), .MAX_TAPS(NT)) u_tap_delay_engine (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .cfg_taps(cfg_taps), .cfg_sub(cfg_sub), .cfg_step(cfg_step),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int s0, input int s1, input int s2,
                           input int l0, input int l1, input int l2,
                           input int h0, input int h1, input int h2);
        stp[0] = s0; stp[1] = s1; stp[2] = s2;
        lo[0] = l0;  lo[1] = l1;  lo[2] = l2;
        hi[0] = h0;  hi[1] = h1;  hi[2] = h2;
        for (int i = 0; i < NT; i++) begin
            cfg_step[i*AW +: AW] = AW'(stp[i]);
            cfg_lo[i*AW +: AW]   = AW'(lo[i]);
            cfg_hi[i*AW +: AW]   = AW'(hi[i]);
        end
    endtask

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[23:8]));
    endfunction

    // R7 model of one sweeper step
    task automatic model_sweep();
        for (int i = 0; i < NT; i++) begin
            if (m_up[i] != 0) begin
                if (m_ofs[i] + stp[i] >= hi[i]) begin
                    m_ofs[i] = hi[i]; m_up[i] = 0;
                end else begin
                    m_ofs[i] = m_ofs[i] + stp[i];
                end
            end else begin
                if (m_ofs[i] <= lo[i] + stp[i]) begin
                    m_ofs[i] = lo[i]; m_up[i] = 1;
                end else begin
                    m_ofs[i] = m_ofs[i] - stp[i];
                end
            end
        end
    endtask

    // apply one sample; optionally inject a strobe while busy (R8)
    task automatic send(input int x, input bit inject, input string tag);
        int n;
        int acc;
        int lat;
        int d;
        bit saw_ovr;
        n = int'(cfg_taps);
        hist[k] = x;
        acc = x;
        for (int i = 0; i < n; i++) begin
            d = hist[k - m_ofs[i]] >>> 1;
            acc = cfg_sub[i] ? acc - d : acc + d;
        end
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;

        @(negedge clk);
        smp_in = SW'(x);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        lat = 0;
        saw_ovr = 0;
        while (!out_valid && lat < 40) begin
            if (inject && lat == 1) begin
                smp_in = SW'(next_rand());
                smp_valid = 1'b1;
            end
            @(negedge clk);
            smp_valid = 1'b0;
            if (overrun) saw_ovr = 1;
            lat++;
        end
        chk({tag, " R2 latency"}, lat, n + 3);
        chk({tag, " R4/R5/R6 data"}, int'($signed(out_data)), acc);
        @(negedge clk);
        chk({tag, " R2 strobe width"}, int'(out_valid), 0);
        if (inject) begin
            chk({tag, " R8 overrun pulse"}, int'(saw_ovr), 1);
            // dropped sample must yield no second result
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (out_valid) chk({tag, " R8 no extra result"}, 1, 0);
            end
        end
        k++;
        model_sweep();
    endtask

    initial begin
        for (int i = 0; i < NT; i++) begin
            m_ofs[i] = 0;
            m_up[i]  = 1;
        end
        set_cfg(4, 2, 2, 4, 0, 10, 40, 20, 63);
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset overrun", int'(overrun), 0);
        chk("R1 reset out_data", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release out_valid", int'(out_valid), 0);
        chk("R1 after release out_data", int'(out_data), 0);

        // R3: no taps, fill the ring (also R6 wrap through DEPTH)
        cfg_taps = 2'd0;
        for (int s = 0; s < DEP + 5; s++) send(next_rand(), 0, "R3 fill");

        // R4/R6/R7: three swept taps, mixed signs
        cfg_taps = 2'd3;
        cfg_sub  = 3'b010;
        for (int s = 0; s < 250; s++) send(next_rand(), 0, "R4 three taps");

        // R4: two and one taps, different signs and sweep ranges
        cfg_taps = 2'd2;
        cfg_sub  = 3'b001;
        set_cfg(2, 4, 2, 0, 3, 1, 63, 33, 9);
        for (int s = 0; s < 120; s++) send(next_rand(), 0, "R4 two taps");
        cfg_taps = 2'd1;
        cfg_sub  = 3'b000;
        for (int s = 0; s < 60; s++) send(next_rand(), 0, "R4 one tap");

        // R5: positive and negative clipping
        cfg_taps = 2'd3;
        cfg_sub  = 3'b000;
        for (int s = 0; s < 70; s++) send(32767 - (s % 3), 0, "R5 high clip");
        for (int s = 0; s < 70; s++) send(-32768 + (s % 3), 0, "R5 low clip");
        cfg_sub  = 3'b111;
        for (int s = 0; s < 10; s++) send(-32768, 0, "R5 low clip sub");
        for (int s = 0; s < 70; s++) send(32767, 0, "R5 pos plateau");
        for (int s = 0; s < 10; s++) send(-32700, 0, "R5 sub underflow");

        // R8: strobes while busy are dropped without side effects
        cfg_sub = 3'b100;
        set_cfg(4, 2, 2, 4, 0, 10, 40, 20, 63);
        for (int s = 0; s < 40; s++) send(next_rand(), (s % 4) == 1, "R8 overrun");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule